// File: doc/BRIEF.md
# Pixel Blink Control Unit

This block makes selected pixels of a display stream blink. A frame counter advances on each frame-end strobe. Each time it has counted a programmable number of frames it inverts one global blink phase bit, so every blinking pixel blinks at the same rate and in the same phase. Each incoming pixel carries a blink flag. A pixel is altered only when its flag is set and the phase bit is high. All other pixels leave the block unchanged.

For 4 and 8 bits per pixel, the pixel is a colour-lookup index. During the blink phase, the low index bits are combined with a mask using AND, OR or XOR. A palette entry can then hold the alternate colour, for example index 0x11 with mask 0x30 under XOR becomes 0x21. For 16 and 24 bits per pixel, setting a bypass control applies arithmetic to each 8-bit channel instead. The choices are: replace with a background value, halve (dimmer), add with saturation (brighter), or add with wraparound (offset). The output is registered, with one cycle of latency for every pixel.

Top module: `blink_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pix_out` is 0 and `blink_phase` is 0.
- R2: With `blink_rate` = N > 0, `blink_phase` inverts on the clock edge that samples the N-th `frame_end` pulse since the last inversion or since reset. On every other cycle it holds its value.
- R3: While `blink_rate` is 0, the frame count is cleared and `blink_phase` is forced to 0 on the next edge.
- R4: A pixel with `blink_flag` low, or any pixel sampled while `blink_phase` is 0, appears unchanged on `pix_out`.
- R5: With `bpp_sel` = 1 (8 bpp), a blinking pixel's bits 7:0 become AND, OR or XOR of those bits with `blink_mask`, for `blink_op` = 0, 1 or 2 respectively. Bits 23:8 are unchanged, so 0x11 under XOR with mask 0x30 gives 0x21.
- R6: With `bpp_sel` = 0 (4 bpp), the lookup operation applies only to bits 3:0, and bits 23:4 are unchanged.
- R7: In lookup mode (`bpp_sel` 0 or 1), `blink_op` = 3 leaves the pixel unchanged.
- R8: With `bpp_sel` = 2 (16 bpp) or 3 (24 bpp) and `lut_bypass` low, a blinking pixel is unchanged.
- R9: With bypass and `blink_op` = 0 (background), each active channel is replaced by the matching channel of `ofs_val`. In 16 bpp the active channels are bits 15:0 and bits 23:16 pass through. In 24 bpp all three channels are active.
- R10: With bypass and `blink_op` = 1 (dimmer), each active 8-bit channel is shifted right by one.
- R11: With bypass and `blink_op` = 2 (brighter), each active channel becomes channel + offset channel, limited to 0xFF.
- R12: With bypass and `blink_op` = 3 (offset), each active channel becomes (channel + offset channel) mod 256.
- R13: The result for a pixel sampled on a clock edge appears on `pix_out` right after that edge. That is one cycle of latency, the same in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | 24 | Incoming pixel or lookup index |
| blink_flag | input | 1 | Marks the pixel as a blinking pixel |
| frame_end | input | 1 | One-cycle strobe at the end of each frame |
| blink_rate | input | 8 | Frames per blink half-period; 0 disables blinking |
| blink_mask | input | 8 | Mask for lookup-index blinking |
| ofs_val | input | 24 | Background / offset value, three 8-bit channels |
| bpp_sel | input | 2 | 0: 4 bpp, 1: 8 bpp, 2: 16 bpp, 3: 24 bpp |
| lut_bypass | input | 1 | Selects the arithmetic modes for 16/24 bpp |
| blink_op | input | 2 | Operation code; meaning per R5, R7, R9 to R12 |
| pix_out | output | 24 | Registered modified pixel |
| blink_phase | output | 1 | Current global blink phase |

## Verification
A pixel driven before a clock edge is due on `pix_out` immediately after that edge. The bench therefore drives on the falling edge, waits for one rising edge, and compares a moment later. A frame-end strobe changes `blink_phase` on the edge that samples it, so phase checks are made right after that edge and pixel sweeps start only once the phase has settled. The pixel sweep covers every combination of pixel depth, bypass, operation, flag and phase over a set of pixel values that include saturation and wraparound corners. Expected results come from a per-channel arithmetic model in the bench.

// File: rtl/blink_pkg.sv
package blink_pkg;
  localparam logic [1:0] BPP_4  = 2'd0;
  localparam logic [1:0] BPP_8  = 2'd1;
  localparam logic [1:0] BPP_16 = 2'd2;
  localparam logic [1:0] BPP_24 = 2'd3;

  // lookup-path operations
  localparam logic [1:0] LOP_AND  = 2'd0;
  localparam logic [1:0] LOP_OR   = 2'd1;
  localparam logic [1:0] LOP_XOR  = 2'd2;
  localparam logic [1:0] LOP_NONE = 2'd3;

  // direct-path operations
  localparam logic [1:0] DOP_BKGND  = 2'd0;
  localparam logic [1:0] DOP_DIM    = 2'd1;
  localparam logic [1:0] DOP_BRIGHT = 2'd2;
  localparam logic [1:0] DOP_WRAP   = 2'd3;
endpackage

// File: rtl/blink_timer.sv
module blink_timer #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_end,
  input  logic [RATE_W-1:0] rate,
  output logic              phase
);
  logic [RATE_W-1:0] frame_cnt;
  logic              last_frame;

  assign last_frame = (frame_cnt >= rate - RATE_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_cnt <= '0;
      phase     <= 1'b0;
    end else if (rate == '0) begin
      frame_cnt <= '0;
      phase     <= 1'b0;
    end else if (frame_end) begin
      if (last_frame) begin
        frame_cnt <= '0;
        phase     <= ~phase;
      end else begin
        frame_cnt <= frame_cnt + RATE_W'(1);
      end
    end
  end

  // R3
  rate_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rate == '0) |=> !phase);

  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!frame_end && rate != '0) |=> $stable(phase));
endmodule

// File: rtl/blink_lut_path.sv
module blink_lut_path
  import blink_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NARROW_W = 4
) (
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [ADDR_W-1:0] mask,
  input  logic [1:0]        op,
  input  logic              narrow,
  output logic [ADDR_W-1:0] addr_out
);
  localparam logic [ADDR_W-1:0] NARROW_LANES = ADDR_W'((1 << NARROW_W) - 1);

  logic [ADDR_W-1:0] lanes;
  logic [ADDR_W-1:0] combined;

  always_comb begin
    lanes = narrow ? NARROW_LANES : '1;
    case (op)
      LOP_AND: combined = addr_in & mask;
      LOP_OR:  combined = addr_in | mask;
      LOP_XOR: combined = addr_in ^ mask;
      default: combined = addr_in;
    endcase
    addr_out = (addr_in & ~lanes) | (combined & lanes);
  end
endmodule

// File: rtl/blink_direct_path.sv
module blink_direct_path
  import blink_pkg::*;
#(
  parameter int CH_W       = 8,
  parameter int NCH        = 3,
  parameter int NCH_NARROW = 2
) (
  input  logic [NCH*CH_W-1:0] pix_in,
  input  logic [NCH*CH_W-1:0] ofs,
  input  logic [1:0]          op,
  input  logic                narrow,
  output logic [NCH*CH_W-1:0] pix_out
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CH_W-1:0] ch, oc, res;
    logic [CH_W:0]   sum;
    logic            active;

    assign ch     = pix_in[c*CH_W +: CH_W];
    assign oc     = ofs[c*CH_W +: CH_W];
    assign sum    = {1'b0, ch} + {1'b0, oc};
    assign active = !narrow || (c < NCH_NARROW);

    always_comb begin
      case (op)
        DOP_BKGND:  res = oc;
        DOP_DIM:    res = ch >> 1;
        DOP_BRIGHT: res = sum[CH_W] ? '1 : sum[CH_W-1:0];
        default:    res = sum[CH_W-1:0];
      endcase
    end

    assign pix_out[c*CH_W +: CH_W] = active ? res : ch;
  end
endmodule

// File: rtl/blink_unit.sv
module blink_unit
  import blink_pkg::*;
#(
  parameter int PIX_W  = 24,
  parameter int CH_W   = 8,
  parameter int ADDR_W = 8,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PIX_W-1:0]  pix_in,
  input  logic              blink_flag,
  input  logic              frame_end,
  input  logic [RATE_W-1:0] blink_rate,
  input  logic [ADDR_W-1:0] blink_mask,
  input  logic [PIX_W-1:0]  ofs_val,
  input  logic [1:0]        bpp_sel,
  input  logic              lut_bypass,
  input  logic [1:0]        blink_op,
  output logic [PIX_W-1:0]  pix_out,
  output logic              blink_phase
);
  localparam int NCH    = PIX_W / CH_W;
  localparam int NCH_16 = 16 / CH_W;

  logic [ADDR_W-1:0] lut_addr;
  logic [PIX_W-1:0]  direct_pix;
  logic [PIX_W-1:0]  next_pix;

  blink_timer #(.RATE_W(RATE_W)) u_timer (
    .clk(clk), .rst(rst), .frame_end(frame_end),
    .rate(blink_rate), .phase(blink_phase)
  );

  blink_lut_path #(.ADDR_W(ADDR_W), .NARROW_W(4)) u_lut (
    .addr_in(pix_in[ADDR_W-1:0]), .mask(blink_mask), .op(blink_op),
    .narrow(bpp_sel == BPP_4), .addr_out(lut_addr)
  );

  blink_direct_path #(.CH_W(CH_W), .NCH(NCH), .NCH_NARROW(NCH_16)) u_direct (
    .pix_in(pix_in), .ofs(ofs_val), .op(blink_op),
    .narrow(bpp_sel == BPP_16), .pix_out(direct_pix)
  );

  always_comb begin
    next_pix = pix_in;
    if (blink_flag && blink_phase) begin
      if (bpp_sel == BPP_4 || bpp_sel == BPP_8)
        next_pix = {pix_in[PIX_W-1:ADDR_W], lut_addr};
      else if (lut_bypass)
        next_pix = direct_pix;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pix_out <= '0;
    else     pix_out <= next_pix;
  end

  // R4
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    (!blink_flag || !blink_phase) |=> pix_out == $past(pix_in));

  // R11
  bright_mono_chk: assert property (@(posedge clk) disable iff (rst)
    (blink_flag && blink_phase && lut_bypass && bpp_sel == BPP_24 &&
     blink_op == DOP_BRIGHT) |=> pix_out[CH_W-1:0] >= $past(pix_in[CH_W-1:0]));

  // R10
  dim_top_chk: assert property (@(posedge clk) disable iff (rst)
    (blink_flag && blink_phase && lut_bypass && bpp_sel == BPP_24 &&
     blink_op == DOP_DIM) |=> !pix_out[PIX_W-1]);

  // R8
  no_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    (bpp_sel[1] && !lut_bypass) |=> pix_out == $past(pix_in));
endmodule

// File: tb/sim_blink_unit.sv
module sim_blink_unit;
  localparam int CLK_P = 10;

  logic        clk = 0;
  logic        rst = 1;
  logic [23:0] pix_in = '0;
  logic        blink_flag = 0;
  logic        frame_end = 0;
  logic [7:0]  blink_rate = '0;
  logic [7:0]  blink_mask = 8'h30;
  logic [23:0] ofs_val = 24'h40C010;
  logic [1:0]  bpp_sel = '0;
  logic        lut_bypass = 0;
  logic [1:0]  blink_op = '0;
  logic [23:0] pix_out;
  logic        blink_phase;

  int n_cmp = 0;
  int n_bad = 0;
  bit exp_ph = 0;
  int exp_cnt = 0;

  blink_unit u0 (
    .clk(clk), .rst(rst), .pix_in(pix_in), .blink_flag(blink_flag),
    .frame_end(frame_end), .blink_rate(blink_rate), .blink_mask(blink_mask),
    .ofs_val(ofs_val), .bpp_sel(bpp_sel), .lut_bypass(lut_bypass),
    .blink_op(blink_op), .pix_out(pix_out), .blink_phase(blink_phase)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string req, int act, int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic int model(int pix, bit flag, bit ph, int bpp, bit byp,
                               int op, int mask, int ofs);
    int lm, a, r, ch, oc, s, n, nch;
    if (!flag || !ph) return pix;
    if (bpp < 2) begin
      lm = (bpp == 0) ? 'hF : 'hFF;
      a = pix & lm;
      case (op)
        0: a = a & mask;
        1: a = a | mask;
        2: a = a ^ mask;
        default: a = a;
      endcase
      return (pix & ~lm) | (a & lm);
    end
    if (!byp) return pix;
    nch = (bpp == 2) ? 2 : 3;
    r = pix;
    for (int c = 0; c < nch; c++) begin
      ch = (pix >> (8*c)) & 255;
      oc = (ofs >> (8*c)) & 255;
      case (op)
        0: n = oc;
        1: n = ch / 2;
        2: begin s = ch + oc; n = (s > 255) ? 255 : s; end
        default: n = (ch + oc) % 256;
      endcase
      r = (r & ~(255 << (8*c))) | (n << (8*c));
    end
    return r;
  endfunction

  task automatic frame_pulse(string req);
    @(negedge clk);
    frame_end = 1;
    @(posedge clk);
    if (blink_rate != 0) begin
      exp_cnt++;
      if (exp_cnt >= blink_rate) begin exp_cnt = 0; exp_ph = ~exp_ph; end
    end
    #1;
    chk(req, blink_phase, exp_ph);
    @(negedge clk);
    frame_end = 0;
  endtask

  task automatic drive_pix(string req, int pix, bit flag);
    @(negedge clk);
    pix_in = pix[23:0];
    blink_flag = flag;
    @(posedge clk);
    #1;
    chk(req, pix_out, model(pix, flag, exp_ph, bpp_sel, lut_bypass, blink_op,
                            blink_mask, ofs_val) & 'hFFFFFF);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int vals[8] = '{'h000000, 'hFFFFFF, 'h112233, 'h80F0C8, 'hA5A5A5,
                    'h0102FE, 'h7F3F11, 'hC05A01};
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset pix", pix_out, 0);
    chk("R1 reset phase", blink_phase, 0);
    @(negedge clk);
    rst = 0;
    @(posedge clk); #1;
    chk("R1 first cycle pix", pix_out, 0);
    chk("R1 first cycle phase", blink_phase, 0);

    // R3: rate zero, pulses do nothing
    frame_pulse("R3 rate zero");
    frame_pulse("R3 rate zero");

    // R2: rate 3 toggles every third pulse
    @(negedge clk); blink_rate = 3;
    for (int i = 0; i < 7; i++) frame_pulse("R2 rate 3");
    // R3: rate set to zero clears phase
    @(negedge clk); blink_rate = 0;
    @(posedge clk); #1;
    exp_ph = 0; exp_cnt = 0;
    chk("R3 clear on zero", blink_phase, 0);

    // R5 example with 8 bpp XOR
    @(negedge clk); blink_rate = 1;
    frame_pulse("R2 rate 1");
    @(negedge clk); bpp_sel = 1; blink_op = 2; lut_bypass = 0;
    drive_pix("R5 xor example", 'h000011, 1);
    chk("R5 example value", pix_out, 'h000021);

    // R4..R13 sweep, both phases
    for (int ph = 0; ph < 2; ph++) begin
      if (exp_ph != ph[0]) frame_pulse("R2 set phase");
      for (int b = 0; b < 4; b++)
        for (int y = 0; y < 2; y++)
          for (int m = 0; m < 4; m++) begin
            @(negedge clk);
            bpp_sel = b[1:0]; lut_bypass = y[0]; blink_op = m[1:0];
            for (int f = 0; f < 2; f++)
              for (int v = 0; v < 8; v++) begin
                if (b == 1)      drive_pix("R5/R7 8bpp R13", vals[v], f[0]);
                else if (b == 0) drive_pix("R6/R7 4bpp R4", vals[v], f[0]);
                else if (y == 0) drive_pix("R8 no bypass", vals[v], f[0]);
                else if (m == 0) drive_pix("R9 background", vals[v], f[0]);
                else if (m == 1) drive_pix("R10 dimmer", vals[v], f[0]);
                else if (m == 2) drive_pix("R11 brighter", vals[v], f[0]);
                else             drive_pix("R12 offset", vals[v], f[0]);
              end
          end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule